// File: doc/BRIEF.md
# Paged receive ring buffer manager

This block places incoming frames into a circular region of local packet memory that is cut into 256-byte pages. The receive region is the contiguous run of pages from a programmed start page up to, but not including, a programmed stop page. A current-page register tells the block where the next frame begins. A boundary register, owned by the host, marks the oldest page the host has not yet consumed. Each frame's payload bytes go out on a byte-wide memory write port. They start at offset 4 of the current page and continue page after page, wrapping from the last page of the region back to the start page.

Once the payload is complete, the block writes a 4-byte header at offsets 0 to 3 of the frame's first page. The header holds the receive status, the page where the following frame will begin, and the byte count (frame length plus 4, low byte first). The current page then moves to that next page. Because the header is written last, the host never finds a half-written frame.

If a frame would write into the boundary page, or would leave the next frame starting on it, the block discards the frame. It raises a sticky overwrite flag and enters a stopped state, shown by a reset-status flag. In that state every frame is discarded until the host moves the boundary. Each discarded frame is counted in a saturating missed-frame tally, and the tally raises a counter-overflow flag when its top bit becomes set.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset, cur_page, bnd_page, ovw_flag, rst_flag, miss_count, cnt_ovf, frm_status and mem_we are all zero.
- R2: A stored frame's payload byte k is written at page-relative linear offset 4+k from the frame's first page. mem_addr is {page, offset}, so offset 255 is followed by offset 0 of the next ring page.
- R3: The ring page after (cfg_stop_page - 1) is cfg_start_page, for both data placement and the next-page header field; no write leaves the range [start, stop).
- R4: After the payload, the header is written at offsets 0..3 of the first page: byte 0 = rx_status with bit 4 cleared, byte 1 = next-frame page, byte 2 = (length+4) low byte, byte 3 = (length+4) high byte.
- R5: After a stored frame, cur_page becomes the next-frame page; cur_page changes only through that update or a cur_wr_en write.
- R6: If any page the frame occupies equals bnd_page, or its next-frame page equals bnd_page, the frame is dropped. ovw_flag and rst_flag are set, no header is written and cur_page is unchanged.
- R7: While rst_flag is set, incoming frames cause no memory writes and are counted as missed. rst_flag clears only when bnd_page is written with a value different from its present one.
- R8: Each dropped frame increments miss_count and reports frm_status = rx_status with bit 4 set; a stored frame reports rx_status with bit 4 cleared.
- R9: miss_count saturates at all ones; cnt_ovf is set when the counter's most significant bit becomes set; tally_clr clears both.
- R10: ovw_clr clears ovw_flag but leaves rst_flag unchanged.
- R11: rx_valid and rx_data outside a frame (no rx_sof) cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_page | input | 8 | First page of the receive region |
| cfg_stop_page | input | 8 | Page just past the receive region |
| cur_wr_en | input | 1 | Load the current-page register |
| cur_wr_data | input | 8 | Value for the current-page register |
| bnd_wr_en | input | 1 | Host write of the boundary page |
| bnd_wr_data | input | 8 | New boundary page |
| ovw_clr | input | 1 | Clear the overwrite flag |
| tally_clr | input | 1 | Clear the missed-frame tally and its overflow flag |
| rx_sof | input | 1 | Frame start strobe (cycle of its own) |
| rx_valid | input | 1 | Payload byte valid |
| rx_data | input | 8 | Payload byte |
| rx_eof | input | 1 | Frame end strobe (cycle of its own) |
| rx_status | input | 8 | Frame status, sampled with rx_eof |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current write page |
| bnd_page | output | 8 | Boundary page |
| ovw_flag | output | 1 | Sticky overwrite flag |
| rst_flag | output | 1 | Stopped state after an overwrite |
| miss_count | output | TALLY_W | Missed-frame tally |
| cnt_ovf | output | 1 | Tally most significant bit has been set |
| frm_status | output | 8 | Status of the last finished frame |
| frm_status_vld | output | 1 | One-cycle pulse when frm_status updates |

## Verification
The hardest situation to reach is an overrun in the middle of a payload. The frame must already be on its second or later page when it lands on the host's boundary, and the ring must be nearly full. Directed frames first walk the current page around the wrap point with the boundary held just behind, then send a frame long enough to reach the boundary page. Random frame lengths and random boundary moves then hit the page-exact fill, the next-page check and the stopped state in many combinations. A long run of empty frames in the stopped state drives the tally across its top bit and into saturation.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int PG_W      = 8;
  localparam int OFS_W     = 8;
  localparam int ADDR_W    = PG_W + OFS_W;
  localparam int LEN_W     = 16;
  localparam int HDR_BYTES = 4;
  localparam int MISS_BIT  = 4;

  typedef logic [PG_W-1:0] page_t;
  typedef enum logic [1:0] {FS_IDLE, FS_DATA, FS_DROP, FS_HDR} fstate_e;

  // next page inside [first, last_excl)
  function automatic page_t ring_step(page_t p, page_t first, page_t last_excl);
    page_t n;
    n = p + page_t'(1);
    return (n == last_excl) ? first : n;
  endfunction

  // header byte selected by index: status, next page, count low, count high
  function automatic logic [7:0] hdr_byte(logic [1:0] idx, logic [7:0] st,
                                          page_t nxt, logic [LEN_W-1:0] cnt);
    logic [7:0] b;
    case (idx)
      2'd0:    b = st;
      2'd1:    b = 8'(nxt);
      2'd2:    b = cnt[7:0];
      default: b = 8'(cnt >> 8);
    endcase
    return b;
  endfunction

  function automatic logic [7:0] stored_status(logic [7:0] s);
    return s & ~(8'(1) << MISS_BIT);
  endfunction

  function automatic logic [7:0] missed_status(logic [7:0] s);
    return s | (8'(1) << MISS_BIT);
  endfunction
endpackage

// File: rtl/rxr_ptr_regs.sv
module rxr_ptr_regs
  import rxr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cur_wr_en,
  input  page_t cur_wr_data,
  input  logic  bnd_wr_en,
  input  page_t bnd_wr_data,
  input  logic  ovw_clr,
  input  logic  commit,
  input  page_t commit_pg,
  input  logic  ovr_evt,
  output page_t cur_pg,
  output page_t bnd_pg,
  output logic  ovw_flag,
  output logic  stop_flag
);
  logic bnd_moved;
  assign bnd_moved = bnd_wr_en && (bnd_wr_data != bnd_pg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pg    <= '0;
      bnd_pg    <= '0;
      ovw_flag  <= 1'b0;
      stop_flag <= 1'b0;
    end else begin
      if (commit)         cur_pg <= commit_pg;
      else if (cur_wr_en) cur_pg <= cur_wr_data;
      if (bnd_wr_en) bnd_pg <= bnd_wr_data;
      if (ovr_evt) begin
        ovw_flag  <= 1'b1;
        stop_flag <= 1'b1;
      end else begin
        if (ovw_clr)   ovw_flag  <= 1'b0;
        if (bnd_moved) stop_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxr_tally.sv
module rxr_tally #(
  parameter int TALLY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_evt,
  input  logic               clr,
  output logic [TALLY_W-1:0] count,
  output logic               msb_seen
);
  localparam logic [TALLY_W-1:0] ONE = TALLY_W'(1);
  logic [TALLY_W-1:0] cnt_inc;
  logic               at_max;

  assign cnt_inc = count + ONE;
  assign at_max  = &count;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      count    <= '0;
      msb_seen <= 1'b0;
    end else if (miss_evt && !at_max) begin
      count    <= cnt_inc;
      msb_seen <= msb_seen | cnt_inc[TALLY_W-1];
    end
  end
endmodule

// File: rtl/rxr_frame_wr.sv
module rxr_frame_wr
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  page_t             start_pg,
  input  page_t             stop_pg,
  input  page_t             cur_pg,
  input  page_t             bnd_pg,
  input  logic              stopped,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof,
  input  logic [7:0]        rx_status,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              ovr_evt,
  output logic              miss_evt,
  output logic              hdr_start,
  output logic              commit,
  output page_t             commit_pg,
  output logic [7:0]        frm_status,
  output logic              frm_status_vld
);
  localparam logic [OFS_W-1:0] PAY_OFS = OFS_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);

  fstate_e            state_q;
  page_t              pg_q, first_q, nxt_q;
  logic [OFS_W-1:0]   off_q;
  logic [LEN_W-1:0]   len_q;
  logic [1:0]         hidx_q;
  logic [7:0]         hsta_q;
  page_t              eof_next;
  logic               accept;

  // page where the following frame would begin if the frame ended now
  assign eof_next = (off_q == '0) ? pg_q : ring_step(pg_q, start_pg, stop_pg);

  always_comb begin
    ovr_evt   = 1'b0;
    miss_evt  = 1'b0;
    hdr_start = 1'b0;
    accept    = 1'b0;
    case (state_q)
      FS_IDLE: if (rx_sof && !stopped && (cur_pg == bnd_pg)) ovr_evt = 1'b1;
      FS_DATA: begin
        if (rx_eof) begin
          if (eof_next == bnd_pg) begin
            ovr_evt  = 1'b1;
            miss_evt = 1'b1;
          end else begin
            hdr_start = 1'b1;
          end
        end else if (rx_valid) begin
          if ((off_q == '0) && (pg_q == bnd_pg)) ovr_evt = 1'b1;
          else                                   accept  = 1'b1;
        end
      end
      FS_DROP: if (rx_eof) miss_evt = 1'b1;
      default: ;
    endcase
  end

  assign commit    = (state_q == FS_HDR) && (hidx_q == 2'd3);
  assign commit_pg = nxt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= FS_IDLE;
      pg_q           <= '0;
      first_q        <= '0;
      nxt_q          <= '0;
      off_q          <= '0;
      len_q          <= '0;
      hidx_q         <= '0;
      hsta_q         <= '0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      frm_status     <= '0;
      frm_status_vld <= 1'b0;
    end else begin
      mem_we         <= 1'b0;
      frm_status_vld <= 1'b0;
      case (state_q)
        FS_IDLE: begin
          if (rx_sof) begin
            if (stopped || ovr_evt) begin
              state_q <= FS_DROP;
            end else begin
              state_q <= FS_DATA;
              pg_q    <= cur_pg;
              first_q <= cur_pg;
              off_q   <= PAY_OFS;
              len_q   <= '0;
            end
          end
        end
        FS_DATA: begin
          if (rx_eof) begin
            if (miss_evt) begin
              state_q        <= FS_IDLE;
              frm_status     <= missed_status(rx_status);
              frm_status_vld <= 1'b1;
            end else begin
              state_q <= FS_HDR;
              hsta_q  <= stored_status(rx_status);
              nxt_q   <= eof_next;
              hidx_q  <= '0;
            end
          end else if (ovr_evt) begin
            state_q <= FS_DROP;
          end else if (accept) begin
            mem_we    <= 1'b1;
            mem_addr  <= {pg_q, off_q};
            mem_wdata <= rx_data;
            off_q     <= off_q + OFS_W'(1);
            len_q     <= len_q + LEN_W'(1);
            if (&off_q) pg_q <= ring_step(pg_q, start_pg, stop_pg);
          end
        end
        FS_DROP: begin
          if (rx_eof) begin
            state_q        <= FS_IDLE;
            frm_status     <= missed_status(rx_status);
            frm_status_vld <= 1'b1;
          end
        end
        default: begin
          mem_we    <= 1'b1;
          mem_addr  <= {first_q, OFS_W'(hidx_q)};
          mem_wdata <= hdr_byte(hidx_q, hsta_q, nxt_q, len_q + HDR_LEN);
          hidx_q    <= hidx_q + 2'd1;
          if (hidx_q == 2'd3) begin
            state_q        <= FS_IDLE;
            frm_status     <= hsta_q;
            frm_status_vld <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
  import rxr_pkg::*;
#(
  parameter int TALLY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfg_start_page,
  input  logic [7:0]         cfg_stop_page,
  input  logic               cur_wr_en,
  input  logic [7:0]         cur_wr_data,
  input  logic               bnd_wr_en,
  input  logic [7:0]         bnd_wr_data,
  input  logic               ovw_clr,
  input  logic               tally_clr,
  input  logic               rx_sof,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_eof,
  input  logic [7:0]         rx_status,
  output logic               mem_we,
  output logic [15:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  output logic [7:0]         cur_page,
  output logic [7:0]         bnd_page,
  output logic               ovw_flag,
  output logic               rst_flag,
  output logic [TALLY_W-1:0] miss_count,
  output logic               cnt_ovf,
  output logic [7:0]         frm_status,
  output logic               frm_status_vld
);
  // internal events, named for the checker
  logic  ovr_evt, miss_evt, hdr_start, commit;
  page_t commit_pg;

  rxr_ptr_regs u_ptr (
    .clk(clk), .rst_n(rst_n),
    .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data),
    .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data),
    .ovw_clr(ovw_clr), .commit(commit), .commit_pg(commit_pg),
    .ovr_evt(ovr_evt),
    .cur_pg(cur_page), .bnd_pg(bnd_page),
    .ovw_flag(ovw_flag), .stop_flag(rst_flag)
  );

  rxr_frame_wr u_wr (
    .clk(clk), .rst_n(rst_n),
    .start_pg(cfg_start_page), .stop_pg(cfg_stop_page),
    .cur_pg(cur_page), .bnd_pg(bnd_page), .stopped(rst_flag),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_status(rx_status),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ovr_evt(ovr_evt), .miss_evt(miss_evt), .hdr_start(hdr_start),
    .commit(commit), .commit_pg(commit_pg),
    .frm_status(frm_status), .frm_status_vld(frm_status_vld)
  );

  rxr_tally #(.TALLY_W(TALLY_W)) u_tally (
    .clk(clk), .rst_n(rst_n),
    .miss_evt(miss_evt), .clr(tally_clr),
    .count(miss_count), .msb_seen(cnt_ovf)
  );
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
  parameter int TALLY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         cfg_start_page,
  input logic [7:0]         cfg_stop_page,
  input logic               cur_wr_en,
  input logic               tally_clr,
  input logic               mem_we,
  input logic [15:0]        mem_addr,
  input logic [7:0]         cur_page,
  input logic               ovw_flag,
  input logic               rst_flag,
  input logic [TALLY_W-1:0] miss_count,
  input logic               cnt_ovf,
  input logic               miss_evt,
  input logic               hdr_start,
  input logic               commit
);
  // R3: every write lands inside the receive region
  a_r3_write_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] >= cfg_start_page) && (mem_addr[15:8] < cfg_stop_page));

  // R5: current page moves only on a commit or a load
  a_r5_cur_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !cur_wr_en) |=> $stable(cur_page));

  // R6: an overwrite always enters the stopped state
  a_r6_ovw_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovw_flag) |-> rst_flag);

  // R7: no frame is committed while stopped
  a_r7_no_store_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |-> !hdr_start);

  // R8: a miss adds one to an unsaturated tally
  a_r8_miss_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !tally_clr && !(&miss_count)) |=>
      (miss_count == $past(miss_count) + TALLY_W'(1)));

  // R9: the overflow flag covers a set top bit
  a_r9_ovf_tracks_msb: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count[TALLY_W-1] |-> cnt_ovf);
endmodule

bind rxr_ring_mgr rxr_ring_chk #(.TALLY_W(TALLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_start_page(cfg_start_page), .cfg_stop_page(cfg_stop_page),
  .cur_wr_en(cur_wr_en), .tally_clr(tally_clr),
  .mem_we(mem_we), .mem_addr(mem_addr), .cur_page(cur_page),
  .ovw_flag(ovw_flag), .rst_flag(rst_flag),
  .miss_count(miss_count), .cnt_ovf(cnt_ovf),
  .miss_evt(miss_evt), .hdr_start(hdr_start), .commit(commit)
);

// File: tb/rxr_ring_mgr_tb.sv
module rxr_ring_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam logic [7:0] START = 8'h40;
  localparam logic [7:0] STOP  = 8'h48;

  logic clk = 0, rst_n = 0;
  logic cur_wr_en = 0, bnd_wr_en = 0, ovw_clr = 0, tally_clr = 0;
  logic [7:0] cur_wr_data = 0, bnd_wr_data = 0;
  logic rx_sof = 0, rx_valid = 0, rx_eof = 0;
  logic [7:0] rx_data = 0, rx_status = 0;
  logic mem_we, ovw_flag, rst_flag, cnt_ovf, frm_status_vld;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_page, bnd_page, frm_status;
  logic [TW-1:0] miss_count;

  rxr_ring_mgr #(.TALLY_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_page(START), .cfg_stop_page(STOP),
    .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data),
    .bnd_wr_en(bnd_wr_en), .bnd_wr_data(bnd_wr_data),
    .ovw_clr(ovw_clr), .tally_clr(tally_clr),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_status(rx_status),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .bnd_page(bnd_page),
    .ovw_flag(ovw_flag), .rst_flag(rst_flag),
    .miss_count(miss_count), .cnt_ovf(cnt_ovf),
    .frm_status(frm_status), .frm_status_vld(frm_status_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int wr_cnt = 0;
  bit [7:0] mem_m [int];
  logic [7:0] pay [0:2047];

  // bench model of the ring state
  logic [7:0] m_cur = 0, m_bnd = 0, m_stat = 0;
  bit m_ovw = 0, m_rst = 0, m_covf = 0;
  int m_tally = 0;

  always @(negedge clk) if (mem_we) begin
    mem_m[int'(mem_addr)] = mem_wdata;
    wr_cnt++;
  end

  function automatic logic [7:0] f_next(logic [7:0] p);
    return (p == STOP - 8'd1) ? START : p + 8'd1;
  endfunction
  function automatic logic [7:0] f_prev(logic [7:0] p);
    return (p == START) ? STOP - 8'd1 : p - 8'd1;
  endfunction
  function automatic logic [7:0] rd(int a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_bnd(logic [7:0] v);
    @(negedge clk); bnd_wr_en = 1; bnd_wr_data = v;
    @(negedge clk); bnd_wr_en = 0;
    if (v != m_bnd) m_rst = 0;
    m_bnd = v;
  endtask

  task automatic check_state();
    chk(cur_page == m_cur, "R5", "cur_page", cur_page, m_cur);
    chk(ovw_flag == m_ovw, "R6", "ovw_flag", ovw_flag, m_ovw);
    chk(rst_flag == m_rst, "R7", "rst_flag", rst_flag, m_rst);
    chk(miss_count == TW'(m_tally), "R8", "miss_count", miss_count, m_tally);
    chk(cnt_ovf == m_covf, "R9", "cnt_ovf", cnt_ovf, m_covf);
  endtask

  task automatic run_frame(int len, logic [7:0] st, bit gaps);
    logic [7:0] p0, p, nxt;
    bit stored, ovr;
    int npg, w0, bad;
    logic [31:0] hexp, hact;
    p0 = m_cur; ovr = 0;
    npg = (len + 4 + 255) / 256;
    p = p0;
    for (int i = 0; i < npg; i++) begin
      if (p == m_bnd) ovr = 1;
      p = f_next(p);
    end
    nxt = p;
    if (nxt == m_bnd) ovr = 1;
    stored = !m_rst && !ovr;
    for (int k = 0; k < 4; k++) mem_m[int'({p0, 8'(k)})] = 8'hEE;
    for (int k = 0; k < len; k++) pay[k] = 8'($urandom);
    w0 = wr_cnt;
    @(negedge clk); rx_sof = 1;
    @(negedge clk); rx_sof = 0;
    for (int k = 0; k < len; k++) begin
      if (gaps && ($urandom % 4 == 0)) @(negedge clk);
      rx_valid = 1; rx_data = pay[k];
      @(negedge clk); rx_valid = 0;
    end
    rx_eof = 1; rx_status = st;
    @(negedge clk); rx_eof = 0;
    repeat (8) @(negedge clk);
    if (!stored) begin
      if (m_tally < 255) m_tally++;
      m_stat = st | 8'h10;
      if (!m_rst) begin m_ovw = 1; m_rst = 1; end
      else chk(wr_cnt == w0, "R7", "writes while stopped", wr_cnt - w0, 0);
      hact = {rd({p0,8'd3}), rd({p0,8'd2}), rd({p0,8'd1}), rd({p0,8'd0})};
      chk(hact == 32'hEEEEEEEE, "R6", "header of dropped frame", hact, 32'hEEEEEEEE);
    end else begin
      m_cur = nxt;
      m_stat = st & 8'hEF;
      hexp = {8'((len + 4) >> 8), 8'(len + 4), nxt, m_stat};
      hact = {rd({p0,8'd3}), rd({p0,8'd2}), rd({p0,8'd1}), rd({p0,8'd0})};
      chk(hact == hexp, "R4", "header bytes", hact, hexp);
      bad = 0; p = p0;
      for (int k = 0; k < len; k++) begin
        int lin;
        lin = k + 4;
        if (lin % 256 == 0) p = f_next(p);
        if (rd({p, 8'(lin % 256)}) != pay[k]) bad++;
      end
      chk(bad == 0, "R2", "payload mismatches", bad, 0);
      chk(wr_cnt - w0 == len + 4, "R3", "write count", wr_cnt - w0, len + 4);
    end
    if (m_tally >= 128) m_covf = 1;
    chk(frm_status == m_stat, "R8", "frm_status", frm_status, m_stat);
    check_state();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_page == 0 && bnd_page == 0, "R1", "pointers", {cur_page, bnd_page}, 0);
    chk(!ovw_flag && !rst_flag && !cnt_ovf, "R1", "flags", {ovw_flag, rst_flag, cnt_ovf}, 0);
    chk(miss_count == 0 && frm_status == 0 && !mem_we, "R1", "tally/status/we",
        {miss_count, frm_status, mem_we}, 0);
    rst_n = 1;
    @(negedge clk); cur_wr_en = 1; cur_wr_data = START;
    @(negedge clk); cur_wr_en = 0; m_cur = START;
    host_bnd(f_prev(START));
    // R11 stray bytes outside a frame
    begin
      int w;
      w = wr_cnt;
      rx_valid = 1; rx_data = 8'h5A; repeat (3) @(negedge clk);
      rx_valid = 0; rx_eof = 1; @(negedge clk); rx_eof = 0;
      repeat (4) @(negedge clk);
      chk(wr_cnt == w, "R11", "writes outside frame", wr_cnt - w, 0);
      chk(miss_count == 0, "R11", "miss_count after stray", miss_count, 0);
    end
    run_frame(60, 8'h01, 1);          // R2 R4 R5 simple frame
    run_frame(252, 8'h21, 0);         // page-exact fill
    run_frame(1000, 8'h11, 1);        // multi page, bit 4 cleared in header
    host_bnd(8'h45);
    run_frame(300, 8'h03, 0);         // R3 wraps to start
    chk(m_cur == START, "R3", "model wrapped", m_cur, START);
    run_frame(1400, 8'h01, 0);        // R6 mid-payload overrun
    run_frame(10, 8'h02, 0);          // R7 stopped drop
    @(negedge clk); ovw_clr = 1; @(negedge clk); ovw_clr = 0; m_ovw = 0;
    chk(!ovw_flag && rst_flag, "R10", "ovw cleared, stop kept", {ovw_flag, rst_flag}, 2'b01);
    host_bnd(m_bnd);                  // same value: stays stopped
    chk(rst_flag == 1, "R7", "rst after same-value write", rst_flag, 1);
    host_bnd(f_prev(m_cur));
    chk(rst_flag == 0, "R7", "rst after boundary moved", rst_flag, 0);
    // random phase
    for (int f = 0; f < 40; f++) begin
      int r, len;
      r = $urandom % 8;
      len = (r == 0) ? 252 : (r == 1) ? 508 : (r == 2) ? 0 : int'($urandom % 700);
      run_frame(len, 8'($urandom), 1);
      r = $urandom % 3;
      if (r == 0) host_bnd(f_prev(m_cur));
      else if (r == 1) host_bnd(START + 8'($urandom % 8));
    end
    // R9 tally across top bit and into saturation
    host_bnd(f_prev(m_cur));
    host_bnd(m_cur);
    while (m_tally < 255) begin
      run_frame(0, 8'h00, 0);
      if (m_tally == 128) chk(cnt_ovf == 1, "R9", "ovf at top bit", cnt_ovf, 1);
    end
    run_frame(0, 8'h00, 0);
    chk(miss_count == 8'hFF, "R9", "saturated tally", miss_count, 8'hFF);
    @(negedge clk); tally_clr = 1; @(negedge clk); tally_clr = 0;
    m_tally = 0; m_covf = 0;
    chk(miss_count == 0 && !cnt_ovf, "R9", "tally cleared", {miss_count, cnt_ovf}, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule